// File: doc/BRIEF.md
# Return Target Predictor with Buffer Fallback

This block supplies predicted targets for return instructions in a processor front end. A small last-in-first-out stack records the address following each call. A direct-mapped target buffer, trained by resolved indirect branches, is the second source of targets. When a return is presented, the block registers a target, a valid flag and a 2-bit code that names where the target came from.

A mode input selects which source takes precedence. In stack-first mode the stack answers whenever it holds an entry, and the buffer is used only when the stack is empty. In buffer-first mode a buffer hit always wins, and the stack is consulted only on a miss. A stuff command loads a single safe address into every stack slot and marks the stack full, so a run of returns cannot underflow into the buffer. Flush recovery, decode and fetch sit outside this block.

Top module: `ret_tgt_pred`

## Requirements
- R1: A call pushes `call_pc_i + 4`. In stack-first mode a return on a non-empty stack pops the newest entry and predicts it with source code 01 (stack).
- R2: Stack capacity is the parameter `STK_DEPTH` (default 16, legal 3 to 32). A call on a full stack overwrites the oldest entry and the depth stays at capacity.
- R3: In stack-first mode a return on an empty stack takes the target buffer entry for `ret_pc_i` with source code 10 (buffer). A pop on an empty stack leaves the depth at zero.
- R4: When neither the selected source nor the fallback source can answer, the return gets valid 0 and source code 00.
- R5: In buffer-first mode a buffer hit predicts the return with source 10 at any stack depth. On a buffer miss the stack answers as in R1.
- R6: Every return pops the stack when it is non-empty, whichever source supplied the prediction.
- R7: The buffer has 2^`TB_IDX_W` entries. It is indexed by PC bits [`TB_IDX_W`+1:2] and tagged with the PC bits above them. An update writes the target and sets the entry valid. A lookup hits only on a valid entry with an equal tag, so a PC with the same index and a different tag misses.
- R8: `stuff_i` writes `stuff_addr_i` into every stack slot and sets the depth to capacity. Returns that pop a stuffed slot report source code 11. A call or return presented together with `stuff_i` is ignored: it does not push and it gives no prediction.
- R9: A call and a return in the same cycle act as pop then push. The return predicts the old top, and the new return address becomes the top without a change in depth.
- R10: The prediction is registered and appears on the cycle after the return is presented. In any cycle after one with no accepted return, valid is 0 and the source is 00.
- R11: Reset empties the stack, invalidates every buffer entry and drives valid 0 and source 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_buf_first_i | input | 1 | 1 selects buffer-first precedence, 0 selects stack-first |
| call_i | input | 1 | Call seen at fetch |
| call_pc_i | input | PC_W | PC of the call |
| ret_i | input | 1 | Return seen at fetch |
| ret_pc_i | input | PC_W | PC of the return |
| upd_i | input | 1 | Resolved indirect-branch update |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_tgt_i | input | PC_W | Resolved target |
| stuff_i | input | 1 | Fill the stack with the safe address |
| stuff_addr_i | input | PC_W | Safe address used by the fill |
| pred_valid_o | output | 1 | Registered prediction valid |
| pred_tgt_o | output | PC_W | Registered predicted target |
| pred_src_o | output | 2 | Source: 00 none, 01 stack, 10 buffer, 11 stuffed slot |

## Verification
Nested calls unwound by returns show LIFO order. A run of calls longer than the capacity shows that the oldest entries are overwritten and the depth saturates. Returns on an empty stack, once with a trained buffer entry and once with an aliasing PC, separate the fallback hit from a tag miss. Buffer-first returns followed by a buffer miss show both the precedence and that the stack was popped underneath. Stuff sequences with a following call, and call/return pairs in one cycle on full and empty stacks, check the source codes and the pop-then-push order.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
   typedef enum logic [1:0] {
      SRC_NONE  = 2'b00,
      SRC_STACK = 2'b01,
      SRC_TBUF  = 2'b10,
      SRC_STUFF = 2'b11
   } rtp_src_e;

   localparam int unsigned RTP_INSTR_BYTES = 4;
endpackage

// File: rtl/rtp_stack.sv
module rtp_stack #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned DEPTH = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_i,
   input  logic [PC_W-1:0] push_addr_i,
   input  logic            pop_i,
   input  logic            stuff_i,
   input  logic [PC_W-1:0] stuff_addr_i,
   output logic            top_valid_o,
   output logic [PC_W-1:0] top_addr_o,
   output logic            top_stuffed_o
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [PC_W-1:0]  slot_q [DEPTH];
   logic [DEPTH-1:0] stuffed_q;
   logic [PTR_W-1:0] ptr_q;      // next free slot
   logic [CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0] top_idx, ptr_next_up;
   logic             do_pop, wr_en;
   logic [PTR_W-1:0] wr_idx;

   assign top_idx     = (ptr_q == '0) ? PTR_LAST : ptr_q - 1'b1;
   assign ptr_next_up = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
   assign do_pop      = pop_i && (cnt_q != '0);
   assign wr_en       = push_i;
   assign wr_idx      = do_pop ? top_idx : ptr_q;

   assign top_valid_o   = (cnt_q != '0);
   assign top_addr_o    = slot_q[top_idx];
   assign top_stuffed_o = stuffed_q[top_idx];

   // Pointer and depth
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= '0;
      end else if (stuff_i) begin
         cnt_q <= CNT_FULL;
      end else if (do_pop && push_i) begin
         ptr_q <= ptr_q;
      end else if (do_pop) begin
         ptr_q <= top_idx;
         cnt_q <= cnt_q - 1'b1;
      end else if (push_i) begin
         ptr_q <= ptr_next_up;
         if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end
   end

   // Slot storage
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stuffed_q[g] <= 1'b0;
            end else if (stuff_i) begin
               slot_q[g]    <= stuff_addr_i;
               stuffed_q[g] <= 1'b1;
            end else if (wr_en && wr_idx == PTR_W'(g)) begin
               slot_q[g]    <= push_addr_i;
               stuffed_q[g] <= 1'b0;
            end
         end
      end
   endgenerate

   a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);
   a_r8_stuff_full: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_i |=> cnt_q == CNT_FULL);
   a_r3_underflow_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !stuff_i && cnt_q == '0) |=> cnt_q == '0);
   a_r2_full_push_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !stuff_i && cnt_q == CNT_FULL) |=> cnt_q == CNT_FULL);
endmodule

// File: rtl/rtp_tbuf.sv
module rtp_tbuf #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] look_pc_i,
   output logic            hit_o,
   output logic [PC_W-1:0] tgt_o,
   input  logic            upd_i,
   input  logic [PC_W-1:0] upd_pc_i,
   input  logic [PC_W-1:0] upd_tgt_i
);
   localparam int unsigned ENTRIES = 1 << IDX_W;
   localparam int unsigned TAG_W   = PC_W - IDX_W - 2;

   logic [ENTRIES-1:0] vld;
   logic [TAG_W-1:0]   tag_w [ENTRIES];
   logic [PC_W-1:0]    tgt_w [ENTRIES];

   logic [IDX_W-1:0] l_idx, u_idx;
   logic [TAG_W-1:0] l_tag, u_tag;

   assign l_idx = look_pc_i[IDX_W+1:2];
   assign l_tag = look_pc_i[PC_W-1:IDX_W+2];
   assign u_idx = upd_pc_i[IDX_W+1:2];
   assign u_tag = upd_pc_i[PC_W-1:IDX_W+2];

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
         logic             v_q;
         logic [TAG_W-1:0] t_q;
         logic [PC_W-1:0]  d_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
            end else if (upd_i && u_idx == IDX_W'(g)) begin
               v_q <= 1'b1;
               t_q <= u_tag;
               d_q <= upd_tgt_i;
            end
         end
         assign vld[g]   = v_q;
         assign tag_w[g] = t_q;
         assign tgt_w[g] = d_q;
      end
   endgenerate

   assign hit_o = vld[l_idx] && (tag_w[l_idx] == l_tag);
   assign tgt_o = tgt_w[l_idx];

   a_r7_tb_fill: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> vld[$past(u_idx)]);
endmodule

// File: rtl/ret_tgt_pred.sv
module ret_tgt_pred
   import rtp_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned STK_DEPTH = 16,
   parameter int unsigned TB_IDX_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode_buf_first_i,
   input  logic            call_i,
   input  logic [PC_W-1:0] call_pc_i,
   input  logic            ret_i,
   input  logic [PC_W-1:0] ret_pc_i,
   input  logic            upd_i,
   input  logic [PC_W-1:0] upd_pc_i,
   input  logic [PC_W-1:0] upd_tgt_i,
   input  logic            stuff_i,
   input  logic [PC_W-1:0] stuff_addr_i,
   output logic            pred_valid_o,
   output logic [PC_W-1:0] pred_tgt_o,
   output logic [1:0]      pred_src_o
);
   generate
      if (STK_DEPTH < 3 || STK_DEPTH > 32) begin : g_bad_depth
         $error("STK_DEPTH must lie in 3..32");
      end
      if (PC_W < TB_IDX_W + 4) begin : g_bad_pcw
         $error("PC_W too small for the buffer index and tag");
      end
   endgenerate

   logic            ret_acc, call_acc;
   logic            stk_valid, stk_stuffed, tb_hit;
   logic [PC_W-1:0] stk_addr, tb_tgt;
   logic            nxt_valid;
   logic [PC_W-1:0] nxt_tgt;
   rtp_src_e        nxt_src, src_q;

   assign ret_acc  = ret_i && !stuff_i;
   assign call_acc = call_i && !stuff_i;

   rtp_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_i       (call_acc),
      .push_addr_i  (call_pc_i + PC_W'(RTP_INSTR_BYTES)),
      .pop_i        (ret_acc),
      .stuff_i      (stuff_i),
      .stuff_addr_i (stuff_addr_i),
      .top_valid_o  (stk_valid),
      .top_addr_o   (stk_addr),
      .top_stuffed_o(stk_stuffed)
   );

   rtp_tbuf #(.PC_W(PC_W), .IDX_W(TB_IDX_W)) u_tbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_pc_i(ret_pc_i),
      .hit_o    (tb_hit),
      .tgt_o    (tb_tgt),
      .upd_i    (upd_i),
      .upd_pc_i (upd_pc_i),
      .upd_tgt_i(upd_tgt_i)
   );

   // Source selection
   always_comb begin
      nxt_valid = 1'b0;
      nxt_tgt   = stk_addr;
      nxt_src   = SRC_NONE;
      if (mode_buf_first_i && tb_hit) begin
         nxt_valid = 1'b1;
         nxt_tgt   = tb_tgt;
         nxt_src   = SRC_TBUF;
      end else if (stk_valid) begin
         nxt_valid = 1'b1;
         nxt_tgt   = stk_addr;
         nxt_src   = stk_stuffed ? SRC_STUFF : SRC_STACK;
      end else if (tb_hit) begin
         nxt_valid = 1'b1;
         nxt_tgt   = tb_tgt;
         nxt_src   = SRC_TBUF;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_valid_o <= 1'b0;
         pred_tgt_o   <= '0;
         src_q        <= SRC_NONE;
      end else if (ret_acc) begin
         pred_valid_o <= nxt_valid;
         pred_tgt_o   <= nxt_tgt;
         src_q        <= nxt_src;
      end else begin
         pred_valid_o <= 1'b0;
         src_q        <= SRC_NONE;
      end
   end
   assign pred_src_o = src_q;

   a_r10_idle_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_acc |=> (!pred_valid_o && pred_src_o == 2'b00));
   a_r4_valid_matches_src: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid_o == (pred_src_o != 2'b00));
   a_r5_buf_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_acc && mode_buf_first_i && tb_hit) |=> pred_src_o == 2'b10);
   a_r3_empty_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_acc && !mode_buf_first_i && !stk_valid && tb_hit) |=> pred_src_o == 2'b10);
   a_r8_stuff_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_i |=> !pred_valid_o);
endmodule

// File: tb/test_ret_tgt_pred.sv
module test_ret_tgt_pred;
   localparam int PC_W = 32;
   localparam int DEP  = 16;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            mode_buf_first_i, call_i, ret_i, upd_i, stuff_i;
   logic [PC_W-1:0] call_pc_i, ret_pc_i, upd_pc_i, upd_tgt_i, stuff_addr_i;
   logic            pred_valid_o;
   logic [PC_W-1:0] pred_tgt_o;
   logic [1:0]      pred_src_o;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [PC_W-1:0] MISS_PC = 32'h0000_0F00; // buffer miss
   localparam logic [PC_W-1:0] TRN_PC  = 32'h0000_0040;
   localparam logic [PC_W-1:0] ALIAS_PC = 32'h0000_0080; // same index, other tag

   always #4 clk = ~clk;

   ret_tgt_pred #(.PC_W(PC_W), .STK_DEPTH(DEP), .TB_IDX_W(4)) i_ret_tgt_pred (
      .clk(clk), .rst_n(rst_n), .mode_buf_first_i(mode_buf_first_i),
      .call_i(call_i), .call_pc_i(call_pc_i), .ret_i(ret_i), .ret_pc_i(ret_pc_i),
      .upd_i(upd_i), .upd_pc_i(upd_pc_i), .upd_tgt_i(upd_tgt_i),
      .stuff_i(stuff_i), .stuff_addr_i(stuff_addr_i),
      .pred_valid_o(pred_valid_o), .pred_tgt_o(pred_tgt_o), .pred_src_o(pred_src_o)
   );

   task automatic chk(input string req, input logic ev, input logic [1:0] es,
                      input logic [PC_W-1:0] et);
      n_chk++;
      if (pred_valid_o !== ev || pred_src_o !== es || (ev && pred_tgt_o !== et)) begin
         n_bad++;
         $display("FAIL %s: got v=%0b src=%0b tgt=%h, expected v=%0b src=%0b tgt=%h",
                  req, pred_valid_o, pred_src_o, pred_tgt_o, ev, es, et);
      end
   endtask

   task automatic idle();
      call_i = 0; ret_i = 0; upd_i = 0; stuff_i = 0;
   endtask

   task automatic do_call(input logic [PC_W-1:0] pc);
      @(negedge clk); idle(); call_i = 1; call_pc_i = pc;
      @(negedge clk); idle();
   endtask

   task automatic do_upd(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] t);
      @(negedge clk); idle(); upd_i = 1; upd_pc_i = pc; upd_tgt_i = t;
      @(negedge clk); idle();
   endtask

   task automatic ret_chk(input string req, input logic [PC_W-1:0] pc, input logic ev,
                          input logic [1:0] es, input logic [PC_W-1:0] et);
      @(negedge clk); idle(); ret_i = 1; ret_pc_i = pc;
      @(negedge clk); idle();
      chk(req, ev, es, et);
   endtask

   task automatic t_reset();
      chk("R11 reset outputs idle", 0, 2'b00, '0);
      ret_chk("R11 R4 empty after reset", TRN_PC, 0, 2'b00, '0);
      @(negedge clk);
      chk("R10 idle cycle after return", 0, 2'b00, '0);
   endtask

   task automatic t_lifo();
      do_call(32'h100); do_call(32'h200); do_call(32'h300);
      ret_chk("R1 lifo 1", MISS_PC, 1, 2'b01, 32'h304);
      ret_chk("R1 lifo 2", MISS_PC, 1, 2'b01, 32'h204);
      ret_chk("R1 lifo 3", MISS_PC, 1, 2'b01, 32'h104);
      ret_chk("R4 empty and miss", MISS_PC, 0, 2'b00, '0);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < DEP + 2; i++) do_call(32'h1000 + i * 16);
      for (int i = DEP + 1; i >= 2; i--)
         ret_chk("R2 overflow unwind", MISS_PC, 1, 2'b01, 32'h1000 + i * 16 + 4);
      ret_chk("R2 oldest two overwritten", MISS_PC, 0, 2'b00, '0);
   endtask

   task automatic t_fallback();
      do_upd(TRN_PC, 32'h0000_ABC0);
      ret_chk("R3 empty stack uses buffer", TRN_PC, 1, 2'b10, 32'h0000_ABC0);
      ret_chk("R7 alias tag misses", ALIAS_PC, 0, 2'b00, '0);
   endtask

   task automatic t_buf_first();
      @(negedge clk); mode_buf_first_i = 1;
      do_call(32'h500); do_call(32'h600);
      ret_chk("R5 buffer hit beats stack", TRN_PC, 1, 2'b10, 32'h0000_ABC0);
      ret_chk("R6 stack popped under buffer hit", ALIAS_PC, 1, 2'b01, 32'h504);
      ret_chk("R5 miss and empty", ALIAS_PC, 0, 2'b00, '0);
      @(negedge clk); mode_buf_first_i = 0;
      do_call(32'h520);
      ret_chk("R1 stack-first ignores buffer hit", TRN_PC, 1, 2'b01, 32'h524);
   endtask

   task automatic t_stuff();
      @(negedge clk); idle();
      stuff_i = 1; stuff_addr_i = 32'h000D_EAD0; ret_i = 1; ret_pc_i = TRN_PC;
      call_i = 1; call_pc_i = 32'h7700;
      @(negedge clk); idle();
      chk("R8 return with stuff ignored", 0, 2'b00, '0);
      do_call(32'h700);
      ret_chk("R8 new call on stuffed stack", TRN_PC, 1, 2'b01, 32'h704);
      for (int i = 0; i < DEP - 1; i++)
         ret_chk("R8 stuffed entry", TRN_PC, 1, 2'b11, 32'h000D_EAD0);
      ret_chk("R3 after stuffed drain uses buffer", TRN_PC, 1, 2'b10, 32'h0000_ABC0);
   endtask

   task automatic t_pair();
      do_call(32'h900);
      @(negedge clk); idle();
      call_i = 1; call_pc_i = 32'hA00; ret_i = 1; ret_pc_i = MISS_PC;
      @(negedge clk); idle();
      chk("R9 pair predicts old top", 1, 2'b01, 32'h904);
      ret_chk("R9 pushed address on top", MISS_PC, 1, 2'b01, 32'hA04);
      ret_chk("R9 depth unchanged by pair", MISS_PC, 0, 2'b00, '0);
      @(negedge clk); idle();
      call_i = 1; call_pc_i = 32'hB00; ret_i = 1; ret_pc_i = MISS_PC;
      @(negedge clk); idle();
      chk("R9 pair on empty stack", 0, 2'b00, '0);
      ret_chk("R9 push after empty pop", MISS_PC, 1, 2'b01, 32'hB04);
   endtask

   initial begin
      idle(); mode_buf_first_i = 0; rst_n = 0;
      call_pc_i = '0; ret_pc_i = '0; upd_pc_i = '0; upd_tgt_i = '0; stuff_addr_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_lifo();
      t_overflow();
      t_fallback();
      t_buf_first();
      t_stuff();
      t_pair();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule